// File: doc/BRIEF.md
# Segment Descriptor Access Query Unit

This unit answers four protected-mode selector queries: fetch access rights, fetch segment limit, test readability and test writability. It takes a 16-bit selector, an operation code and the current privilege level (CPL). It looks up an 8-byte descriptor in the global or the local descriptor table through a 32-bit read port. It then returns a zero flag that is set only when every rule for that operation passes. For the two fetch operations it also returns a 32-bit result word.

The unit keeps its own base and limit for each of the two tables, loaded through a small write port. A query starts with a valid/ready handshake. A rejected query does not raise a fault. It produces a one-cycle response with the flag clear and the data word zero. Queries that fail before any memory access skip the two descriptor reads.

Top module: `seg_query_unit`

## Requirements
- R1: `req_ready_o` is high only while idle. Each accepted query yields exactly one response, a single-cycle pulse on `rsp_valid_o`. Selector and CPL are captured at acceptance.
- R2: Op codes are 0 access rights, 1 limit, 2 verify-read and 3 verify-write. A selector with bits 15:2 all zero fails at once for ops 0, 2 and 3, with no memory read. Op 1 does not treat that selector as special.
- R3: Selector bit 2 picks the local table (1) or the global table (0). Bits 1:0 are the requested level (RPL). The descriptor sits at table base + (selector & 0xFFF8). The low dword is read first, then the high dword at +4. When the offset + 7 exceeds the chosen table's limit, the query fails without a read. Both table limits reset to 0.
- R4: High-dword fields are: type 11:8 (code 11, conforming 10, readable/writable 9), S 12 (1 = code/data), DPL 14:13, granularity 23. The privilege check fails when DPL < CPL or DPL < RPL.
- R5: For code/data descriptors in ops 0 and 1, conforming code skips the privilege check. All other code/data descriptors need it to pass.
- R6: For system descriptors (S = 0), op 1 accepts only types 1, 2, 3, 9 and 11, and still needs the privilege check to pass.
- R7: For system descriptors, op 0 accepts only types 1, 2, 3, 4, 5, 9, 11 and 12, and still needs the privilege check to pass.
- R8: A passing op 0 returns the high dword ANDed with 0x00F0FF00.
- R9: A passing op 1 returns the 20-bit limit {high[19:16], low[15:0]}. When bit 23 is set, the limit is shifted left by 12 with ones in bits 11:0.
- R10: Op 2 fails on system descriptors and on non-readable code. It passes readable conforming code without a privilege check. Any other case needs the privilege check.
- R11: Op 3 fails on system descriptors and on all code. For data it needs the privilege check and the writable bit.
- R12: A failed query returns flag 0 and data 0. Verify ops return data 0 even on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Write table base/limit |
| tbl_ldt_i | input | 1 | Table chosen for write: 1 local, 0 global |
| tbl_base_i | input | 32 | Table base byte address |
| tbl_limit_i | input | 16 | Table limit in bytes |
| req_valid_i | input | 1 | Query request valid |
| req_ready_o | output | 1 | Unit idle, request accepted |
| req_op_i | input | 2 | Query operation code |
| req_sel_i | input | 16 | Selector under test |
| req_cpl_i | input | 2 | Current privilege level |
| mem_rd_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Read byte address |
| mem_rvalid_i | input | 1 | Read data valid for the current address |
| mem_rdata_i | input | 32 | Read data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_zf_o | output | 1 | Zero flag: all checks passed |
| rsp_data_o | output | 32 | Rights or limit word |

## Verification
The assertions assume the following environment:
- `mem_rvalid_i` answers only the address shown while `mem_rd_o` is high.
- Table writes happen only while the unit is idle.
- `req_valid_i` is dropped after acceptance.

The bench keeps to these assumptions:
- Its memory model responds at each falling edge to the address it sees.
- It loads the tables before the sweeps begin.
- It issues one query at a time, waiting for the response before the next.

The sweep covers every operation, CPL, RPL, type, S value and DPL.

// File: rtl/seg_query_pkg.sv
package seg_query_pkg;
  typedef enum logic [1:0] {
    OP_LAR  = 2'd0,
    OP_LSL  = 2'd1,
    OP_VERR = 2'd2,
    OP_VERW = 2'd3
  } qop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_DONE = 2'd3
  } qstate_e;

  localparam int unsigned F_RW    = 9;
  localparam int unsigned F_CONF  = 10;
  localparam int unsigned F_CODE  = 11;
  localparam int unsigned F_S     = 12;
  localparam int unsigned F_DPL   = 13;
  localparam int unsigned F_GRAN  = 23;
  localparam logic [31:0] RIGHTS_MASK = 32'h00F0FF00;
  localparam logic [15:0] LSL_SYS_OK  = 16'h0A0E;
  localparam logic [15:0] LAR_SYS_OK  = 16'h1A3E;
endpackage

// File: rtl/seg_table_regs.sv
module seg_table_regs #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16,
  parameter int unsigned NT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          wsel_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] limit_i,
  input  logic [15:0]   sel_i,
  output logic [AW-1:0] addr_o,
  output logic          in_range_o
);
  localparam int unsigned SW = $clog2(NT);

  logic [AW-1:0] base_q [NT];
  logic [LW-1:0] lim_q  [NT];

  for (genvar t = 0; t < NT; t++) begin : g_tbl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[t] <= '0;
        lim_q[t]  <= '0;
      end else if (we_i && (SW'(wsel_i) == SW'(t))) begin
        base_q[t] <= base_i;
        lim_q[t]  <= limit_i;
      end
    end
  end

  logic [SW-1:0] tsel;
  logic [15:0]   offset;
  logic [LW:0]   last_byte;

  assign tsel       = SW'(sel_i[2]);
  assign offset     = {sel_i[15:3], 3'b000};
  assign last_byte  = (LW+1)'(offset) + (LW+1)'(7);
  assign in_range_o = last_byte <= {1'b0, lim_q[tsel]};
  assign addr_o     = base_q[tsel] + AW'(offset);
endmodule

// File: rtl/seg_rights_eval.sv
module seg_rights_eval
  import seg_query_pkg::*;
(
  input  qop_e        op_i,
  input  logic [1:0]  rpl_i,
  input  logic [1:0]  cpl_i,
  input  logic [31:0] lo_i,
  input  logic [31:0] hi_i,
  output logic        pass_o,
  output logic [31:0] data_o
);
  logic [1:0]  dpl;
  logic [3:0]  dtype;
  logic        is_seg, is_code, is_conf, rw, priv_ok;
  logic [19:0] lim20;
  logic [31:0] lim_full;

  assign dpl     = hi_i[F_DPL +: 2];
  assign dtype   = hi_i[F_RW-1 +: 4];
  assign is_seg  = hi_i[F_S];
  assign is_code = hi_i[F_CODE];
  assign is_conf = hi_i[F_CONF];
  assign rw      = hi_i[F_RW];
  assign priv_ok = (dpl >= cpl_i) && (dpl >= rpl_i);
  assign lim20   = {hi_i[19:16], lo_i[15:0]};
  assign lim_full = hi_i[F_GRAN] ? {lim20, 12'hFFF} : {12'h000, lim20};

  always_comb begin
    pass_o = 1'b0;
    data_o = '0;
    unique case (op_i)
      OP_LAR: begin
        if (is_seg) pass_o = (is_code && is_conf) || priv_ok;
        else        pass_o = LAR_SYS_OK[dtype] && priv_ok;
        data_o = hi_i & RIGHTS_MASK;
      end
      OP_LSL: begin
        if (is_seg) pass_o = (is_code && is_conf) || priv_ok;
        else        pass_o = LSL_SYS_OK[dtype] && priv_ok;
        data_o = lim_full;
      end
      OP_VERR: begin
        if (!is_seg)     pass_o = 1'b0;
        else if (is_code) pass_o = rw && (is_conf || priv_ok);
        else              pass_o = priv_ok;
      end
      OP_VERW: pass_o = is_seg && !is_code && priv_ok && rw;
      default: pass_o = 1'b0;
    endcase
    if (!pass_o) data_o = '0;
  end
endmodule

// File: rtl/seg_query_unit.sv
module seg_query_unit
  import seg_query_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tbl_we_i,
  input  logic          tbl_ldt_i,
  input  logic [AW-1:0] tbl_base_i,
  input  logic [LW-1:0] tbl_limit_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [15:0]   req_sel_i,
  input  logic [1:0]    req_cpl_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_zf_o,
  output logic [31:0]   rsp_data_o
);
  qstate_e       state_q;
  qop_e          op_q;
  logic [15:0]   sel_q;
  logic [1:0]    cpl_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   lo_q, hi_q;
  logic          early_fail_q;

  logic [AW-1:0] tbl_addr;
  logic          tbl_in_range;
  logic          accept, null_fail, ev_pass;
  logic [31:0]   ev_data;

  seg_table_regs #(.AW(AW), .LW(LW), .NT(2)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we_i),
    .wsel_i     (tbl_ldt_i),
    .base_i     (tbl_base_i),
    .limit_i    (tbl_limit_i),
    .sel_i      (req_sel_i),
    .addr_o     (tbl_addr),
    .in_range_o (tbl_in_range)
  );

  seg_rights_eval u_eval (
    .op_i   (op_q),
    .rpl_i  (sel_q[1:0]),
    .cpl_i  (cpl_q),
    .lo_i   (lo_q),
    .hi_i   (hi_q),
    .pass_o (ev_pass),
    .data_o (ev_data)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign null_fail   = (req_sel_i[15:2] == '0) && (qop_e'(req_op_i) != OP_LSL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      op_q         <= OP_LAR;
      sel_q        <= '0;
      cpl_q        <= '0;
      addr_q       <= '0;
      lo_q         <= '0;
      hi_q         <= '0;
      early_fail_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q         <= qop_e'(req_op_i);
          sel_q        <= req_sel_i;
          cpl_q        <= req_cpl_i;
          addr_q       <= tbl_addr;
          early_fail_q <= null_fail || !tbl_in_range;
          state_q      <= (null_fail || !tbl_in_range) ? ST_DONE : ST_LO;
        end
        ST_LO: if (mem_rvalid_i) begin
          lo_q    <= mem_rdata_i;
          state_q <= ST_HI;
        end
        ST_HI: if (mem_rvalid_i) begin
          hi_q    <= mem_rdata_i;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_o    = (state_q == ST_LO) || (state_q == ST_HI);
  assign mem_addr_o  = (state_q == ST_HI) ? addr_q + AW'(4) : addr_q;
  assign rsp_valid_o = (state_q == ST_DONE);
  assign rsp_zf_o    = rsp_valid_o && !early_fail_q && ev_pass;
  assign rsp_data_o  = rsp_zf_o ? ev_data : '0;

  assert_accept_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  assert_rsp_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_null_noread_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (sel_q[15:2] != '0) || (op_q == OP_LSL));
  assert_rd_not_rsp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !rsp_valid_o);
  assert_rights_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_zf_o && op_q == OP_LAR |-> (rsp_data_o & ~RIGHTS_MASK) == '0);
  assert_verw_data_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_zf_o && op_q == OP_VERW |-> hi_q[F_S] && !hi_q[F_CODE]);
  assert_fail_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_zf_o |-> rsp_data_o == '0);
endmodule

// File: tb/sim_seg_query_unit.sv
`timescale 1ns/1ps
module sim_seg_query_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0, tbl_ldt = 1'b0;
  logic [31:0] tbl_base = '0;
  logic [15:0] tbl_limit = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [15:0] req_sel = '0;
  logic [1:0]  req_cpl = '0;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_zf;
  logic [31:0] rsp_data;

  int vectors = 0, errors = 0, cycles = 0;
  logic [31:0] mem [0:1023];

  always #2.5 clk = ~clk;

  seg_query_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_we_i(tbl_we), .tbl_ldt_i(tbl_ldt), .tbl_base_i(tbl_base), .tbl_limit_i(tbl_limit),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_sel_i(req_sel), .req_cpl_i(req_cpl),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_zf_o(rsp_zf), .rsp_data_o(rsp_data)
  );

  always @(negedge clk) begin
    mem_rvalid <= mem_rd;
    mem_rdata  <= mem_rd ? mem[mem_addr[11:2]] : 32'h0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_tbl(input logic ldt, input logic [31:0] b, input logic [15:0] l);
    @(negedge clk);
    tbl_we = 1'b1; tbl_ldt = ldt; tbl_base = b; tbl_limit = l;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run_q(input logic [1:0] op, input logic [15:0] sel, input logic [1:0] cpl,
                       output logic zf, output logic [31:0] data, output int reads);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_sel = sel; req_cpl = cpl;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_sel = 16'hFFFF; req_cpl = 2'd3; req_op = ~op;
    reads = 0; zf = 1'b0; data = 32'hDEADBEEF;
    for (int k = 0; k < 20; k++) begin
      if (mem_rd) reads++;
      if (rsp_valid) begin
        zf = rsp_zf; data = rsp_data;
        break;
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [32:0] model(input logic [1:0] op, input logic [1:0] rpl,
                                        input logic [1:0] cpl, input logic [31:0] lo,
                                        input logic [31:0] hi);
    logic s, cd, cf, w, pr, ok;
    logic [3:0] ty;
    logic [31:0] d;
    s = hi[12]; cd = hi[11]; cf = hi[10]; w = hi[9]; ty = hi[11:8];
    pr = !((hi[14:13] < cpl) || (hi[14:13] < rpl));
    d = 32'h0;
    case (op)
      2'd0: begin
        ok = s ? ((cd && cf) ? 1'b1 : pr)
               : (pr && (ty inside {4'd1,4'd2,4'd3,4'd4,4'd5,4'd9,4'd11,4'd12}));
        d = {8'h00, hi[23:20], 4'h0, hi[15:8], 8'h00};
      end
      2'd1: begin
        ok = s ? ((cd && cf) ? 1'b1 : pr)
               : (pr && (ty inside {4'd1,4'd2,4'd3,4'd9,4'd11}));
        d = hi[23] ? ({12'h0, hi[19:16], lo[15:0]} << 12) | 32'hFFF
                   : {12'h0, hi[19:16], lo[15:0]};
      end
      2'd2: ok = s && (cd ? (w && (cf || pr)) : pr);
      default: ok = s && !cd && w && pr;
    endcase
    if (!ok || op[1]) d = 32'h0;
    return {ok, d};
  endfunction

  function automatic string rq(input logic [1:0] op, input logic s);
    case (op)
      2'd0: return s ? "R5/R8" : "R7";
      2'd1: return s ? "R5/R9" : "R6";
      2'd2: return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    logic zf;
    logic [31:0] d, lo, hi;
    logic [32:0] e;
    int rd;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    #1;
    chk("R1 reset ready", {31'b0, req_ready}, 32'h1);
    chk("R1 reset rsp", {31'b0, rsp_valid}, 32'h0);
    chk("R3 reset rd", {31'b0, mem_rd}, 32'h0);
    #20; rst_n = 1'b1;

    // R3: limits reset to 0, so even a low index is out of range
    run_q(2'd0, 16'h0008, 2'd0, zf, d, rd);
    chk("R3 reset-limit zf", {31'b0, zf}, 32'h0);
    chk("R3 reset-limit reads", rd, 0);

    set_tbl(1'b0, 32'h100, 16'h003F);
    set_tbl(1'b1, 32'h300, 16'h001F);

    // R2: null selector fails without reads, op 1 reads entry 0
    mem[32'h100 >> 2] = 32'h0000_1111;
    mem[(32'h100 >> 2) + 1] = 32'h0003_F200;
    for (int op = 0; op < 4; op++) begin
      for (int r = 0; r < 4; r++) begin
        run_q(op[1:0], 16'(r), 2'd0, zf, d, rd);
        e = model(op[1:0], r[1:0], 2'd0, 32'h0000_1111, 32'h0003_F200);
        if (op == 1) begin
          chk("R2 op1 null zf", {31'b0, zf}, {31'b0, e[32]});
          chk("R2 op1 null data", d, e[31:0]);
          chk("R2 op1 null reads", rd, 2);
        end else begin
          chk("R2 null zf", {31'b0, zf}, 32'h0);
          chk("R2 null reads", rd, 0);
        end
      end
    end

    // R3: global last index in range, local table select and bounds
    mem[(32'h100 + 56) >> 2] = 32'h0000_0777;
    mem[((32'h100 + 56) >> 2) + 1] = 32'h0000_F200;
    run_q(2'd1, 16'h0038, 2'd0, zf, d, rd);
    chk("R3 gdt last zf", {31'b0, zf}, 32'h1);
    chk("R3 gdt last data", d, 32'h0000_0777);
    run_q(2'd1, 16'h0040, 2'd0, zf, d, rd);
    chk("R3 gdt over zf", {31'b0, zf}, 32'h0);
    chk("R3 gdt over reads", rd, 0);
    mem[(32'h300 + 24) >> 2] = 32'h0000_0ABC;
    mem[((32'h300 + 24) >> 2) + 1] = 32'h0001_F200;
    run_q(2'd1, 16'h001C, 2'd0, zf, d, rd);
    chk("R3 ldt last zf", {31'b0, zf}, 32'h1);
    chk("R3 ldt last data", d, 32'h0001_0ABC);
    run_q(2'd1, 16'h0024, 2'd0, zf, d, rd);
    chk("R3 ldt over zf", {31'b0, zf}, 32'h0);
    chk("R3 ldt over reads", rd, 0);

    // R4-R12: sweep op, CPL, RPL, S, type, DPL on global index 1
    for (int s = 0; s < 2; s++)
      for (int ty = 0; ty < 16; ty++)
        for (int dp = 0; dp < 4; dp++) begin
          lo = {16'h5A00 | 16'(ty), 16'(ty * 4099 + dp)};
          hi = {8'hA5, dp[0] ^ ty[0], 3'b101, 4'(ty + dp), 1'b1, dp[1:0], s[0], ty[3:0], 8'h3C};
          mem[(32'h100 + 8) >> 2] = lo;
          mem[((32'h100 + 8) >> 2) + 1] = hi;
          for (int op = 0; op < 4; op++)
            for (int c = 0; c < 4; c++)
              for (int r = 0; r < 4; r++) begin
                run_q(op[1:0], 16'h0008 | 16'(r), c[1:0], zf, d, rd);
                e = model(op[1:0], r[1:0], c[1:0], lo, hi);
                chk({rq(op[1:0], s[0]), " R4 zf"}, {31'b0, zf}, {31'b0, e[32]});
                chk({rq(op[1:0], s[0]), " R12 data"}, d, e[31:0]);
                if (r == 0 && c == 0 && dp == 0) chk("R1 R3 reads", rd, 2);
              end
        end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule